// File: doc/BRIEF.md
# Multicast Port Flush Scanner

This block removes a group of egress ports from every multicast forwarding entry held in an address lookup table. A single start pulse supplies the ports to remove, a VLAN number and a flag that widens the sweep to every VLAN. The scanner then visits each table slot once, from the lowest index to the highest. For each slot it reads the entry, decides whether the entry qualifies, and writes back a reduced entry only when something actually changes. An entry whose port set becomes empty is turned back into a free slot, so later learning can reuse it.

The table itself lives outside the block. The block reaches it through a read port and a separate write port. The read port has a one-cycle latency: data is expected in the cycle after the read enable. The block reports the sweep through a busy level and a one-cycle done pulse.

Top module: `mcast_flush_scan`

## Requirements
- R1: While reset is high and in the first cycle after it, busy, done, the read enable and the write enable are all low.
- R2: A start pulse seen while idle begins a sweep. Busy is high in the next cycle. Reads are issued to addresses 0, 1, …, DEPTH-1 in rising order, one read every two cycles.
- R3: A start pulse that arrives while a sweep is running is ignored. The running sweep keeps its original port set, VLAN and all-VLAN flag, and its read order is unchanged.
- R4: Done is high for exactly one cycle, 2·DEPTH+1 cycles after the cycle in which start was sampled. Busy is low in that same cycle, so a start given during done begins a new sweep at once.
- R5: Only entries whose type field (bits 61:60) holds 1 (address) or 3 (VLAN plus address) are considered. Type 0 (free) and type 2 (VLAN) entries are never written.
- R6: When the all-VLAN flag is low, an entry is skipped unless its VLAN field (bits 59:48) equals the requested VLAN number.
- R7: Only entries with the group bit (bit 40) set are modified. An entry whose address bits 47:0 are all ones (broadcast) is never written.
- R8: An entry whose port set (bits 66 upward, one bit per port) has no port in common with the flush set is not written.
- R9: A qualifying entry is written back to the address it was read from, in the cycle two after its read enable. The flush ports are cleared from its port set and every other bit is kept.
- R10: When the reduced port set is empty, the written entry carries type 0 (free) and a zero port set.
- R11: No write is issued for any entry that is not modified, and none outside a sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begins a sweep when the block is idle |
| flush_mask_i | input | PORTS | Ports to remove from multicast entries |
| vid_i | input | 12 | VLAN number used when the all-VLAN flag is low |
| all_vlan_i | input | 1 | Ignore the VLAN field and sweep every VLAN |
| busy_o | output | 1 | A sweep is in progress |
| done_o | output | 1 | One-cycle pulse when the sweep ends |
| tbl_rd_en_o | output | 1 | Table read enable |
| tbl_rd_addr_o | output | ADDR_W | Table read index |
| tbl_rd_data_i | input | 66+PORTS | Table entry, valid one cycle after the read enable |
| tbl_wr_en_o | output | 1 | Table write enable |
| tbl_wr_addr_o | output | ADDR_W | Table write index |
| tbl_wr_data_o | output | 66+PORTS | Entry to store |

## Verification
Two events meet in the final cycle of a sweep: the last write-back and the done pulse. A new start request can also arrive in that same cycle. The bench gives a start exactly in the done cycle and expects a second sweep to begin. Its expected writes are taken from a shadow copy of the table that already holds the first sweep's results, so a lost or doubled sweep shows up as an address or data mismatch. Separately, a start with a wider port set and the all-VLAN flag is given in the middle of a sweep. The bench then checks that the read sequence does not restart and that the entries this request would have freed stay untouched.

// File: rtl/mcf_pkg.sv
package mcf_pkg;
  // Entry field positions; a neighbouring lookup engine decodes these.
  localparam int TYPE_LSB  = 60;
  localparam int VID_LSB   = 48;
  localparam int VID_W     = 12;
  localparam int MAC_W     = 48;
  localparam int GROUP_BIT = 40;
  localparam int PMASK_LSB = 66;

  typedef enum logic [1:0] {
    ENT_FREE  = 2'd0,
    ENT_ADDR  = 2'd1,
    ENT_VLAN  = 2'd2,
    ENT_VADDR = 2'd3
  } ent_type_e;

  typedef enum logic [1:0] {
    SC_IDLE = 2'd0,
    SC_READ = 2'd1,
    SC_EVAL = 2'd2
  } scan_st_e;
endpackage

// File: rtl/mcf_qualify.sv
module mcf_qualify
  import mcf_pkg::*;
#(
  parameter int PORTS   = 4,
  parameter int ENTRY_W = PMASK_LSB + PORTS
) (
  input  logic [ENTRY_W-1:0] entry_i,
  input  logic [PORTS-1:0]   flush_mask_i,
  input  logic [VID_W-1:0]   vid_i,
  input  logic               all_vlan_i,
  output logic               modify_o,
  output logic [ENTRY_W-1:0] entry_o
);
  ent_type_e        kind;
  logic             is_addr, vid_ok, is_group, is_bcast, overlap;
  logic [PORTS-1:0] cur_mask, left_mask;

  always_comb begin
    kind      = ent_type_e'(entry_i[TYPE_LSB +: 2]);
    is_addr   = (kind == ENT_ADDR) || (kind == ENT_VADDR);
    vid_ok    = all_vlan_i || (entry_i[VID_LSB +: VID_W] == vid_i);
    is_group  = entry_i[GROUP_BIT];
    is_bcast  = &entry_i[MAC_W-1:0];
    cur_mask  = entry_i[PMASK_LSB +: PORTS];
    overlap   = |(cur_mask & flush_mask_i);
    left_mask = cur_mask & ~flush_mask_i;
    modify_o  = is_addr && vid_ok && is_group && !is_bcast && overlap;

    entry_o = entry_i;
    entry_o[PMASK_LSB +: PORTS] = left_mask;
    if (left_mask == '0) entry_o[TYPE_LSB +: 2] = ENT_FREE;
  end
endmodule

// File: rtl/mcf_seq.sv
module mcf_seq
  import mcf_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  output logic              capture_o,
  output logic              eval_o,
  output logic [ADDR_W-1:0] idx_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(DEPTH - 1);

  scan_st_e st;

  assign capture_o = (st == SC_IDLE) && start_i;
  assign eval_o    = (st == SC_EVAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SC_IDLE;
      idx_o     <= '0;
      rd_en_o   <= 1'b0;
      rd_addr_o <= '0;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      rd_en_o <= 1'b0;
      case (st)
        SC_IDLE: if (start_i) begin
          st        <= SC_READ;
          idx_o     <= '0;
          rd_en_o   <= 1'b1;
          rd_addr_o <= '0;
          busy_o    <= 1'b1;
        end
        SC_READ: st <= SC_EVAL;
        SC_EVAL: begin
          if (idx_o == LAST_IDX) begin
            st     <= SC_IDLE;
            busy_o <= 1'b0;
            done_o <= 1'b1;
          end else begin
            idx_o     <= idx_o + 1'b1;
            rd_en_o   <= 1'b1;
            rd_addr_o <= idx_o + 1'b1;
            st        <= SC_READ;
          end
        end
        default: st <= SC_IDLE;
      endcase
    end
  end

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_done_idle_R4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
  assert_read_order_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en_o && rd_addr_o != '0) |-> rd_addr_o == ADDR_W'($past(rd_addr_o, 2) + 1'b1));
  assert_read_in_sweep_R2: assert property (@(posedge clk) disable iff (rst)
    rd_en_o |-> busy_o);
endmodule

// File: rtl/mcast_flush_scan.sv
module mcast_flush_scan
  import mcf_pkg::*;
#(
  parameter int PORTS   = 4,
  parameter int DEPTH   = 64,
  parameter int ENTRY_W = PMASK_LSB + PORTS,
  parameter int ADDR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [PORTS-1:0]   flush_mask_i,
  input  logic [VID_W-1:0]   vid_i,
  input  logic               all_vlan_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               tbl_rd_en_o,
  output logic [ADDR_W-1:0]  tbl_rd_addr_o,
  input  logic [ENTRY_W-1:0] tbl_rd_data_i,
  output logic               tbl_wr_en_o,
  output logic [ADDR_W-1:0]  tbl_wr_addr_o,
  output logic [ENTRY_W-1:0] tbl_wr_data_o
);
  logic               capture, eval;
  logic [ADDR_W-1:0]  idx;
  logic [PORTS-1:0]   flush_q;
  logic [VID_W-1:0]   vid_q;
  logic               all_q;
  logic               modify;
  logic [ENTRY_W-1:0] new_entry;

  mcf_seq #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .capture_o (capture),
    .eval_o    (eval),
    .idx_o     (idx),
    .rd_en_o   (tbl_rd_en_o),
    .rd_addr_o (tbl_rd_addr_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  mcf_qualify #(.PORTS(PORTS), .ENTRY_W(ENTRY_W)) u_qual (
    .entry_i      (tbl_rd_data_i),
    .flush_mask_i (flush_q),
    .vid_i        (vid_q),
    .all_vlan_i   (all_q),
    .modify_o     (modify),
    .entry_o      (new_entry)
  );

  // Request latch: loaded only when a sweep is accepted.
  always_ff @(posedge clk) begin
    if (rst) begin
      flush_q <= '0;
      vid_q   <= '0;
      all_q   <= 1'b0;
    end else if (capture) begin
      flush_q <= flush_mask_i;
      vid_q   <= vid_i;
      all_q   <= all_vlan_i;
    end
  end

  // Write-back register: only changed entries reach the table.
  always_ff @(posedge clk) begin
    if (rst) tbl_wr_en_o <= 1'b0;
    else     tbl_wr_en_o <= eval && modify;
  end

  always_ff @(posedge clk) begin
    tbl_wr_addr_o <= idx;
    tbl_wr_data_o <= new_entry;
  end

  assert_start_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> ($stable(flush_q) && $stable(vid_q) && $stable(all_q)));
  assert_wr_slot_R9: assert property (@(posedge clk) disable iff (rst)
    tbl_wr_en_o |-> tbl_wr_addr_o == $past(tbl_rd_addr_o, 2));
  assert_wr_cleared_R9: assert property (@(posedge clk) disable iff (rst)
    tbl_wr_en_o |-> (tbl_wr_data_o[PMASK_LSB +: PORTS] & flush_q) == '0);
  assert_free_empty_R10: assert property (@(posedge clk) disable iff (rst)
    tbl_wr_en_o |-> ((tbl_wr_data_o[TYPE_LSB +: 2] == ENT_FREE) ==
                     (tbl_wr_data_o[PMASK_LSB +: PORTS] == '0)));
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !done_o) |-> !tbl_wr_en_o);
endmodule

// File: tb/mcast_flush_scan_test.sv
`timescale 1ns/1ps
module mcast_flush_scan_test;
  localparam int PORTS   = 4;
  localparam int DEPTH   = 16;
  localparam int ENTRY_W = 66 + PORTS;
  localparam int ADDR_W  = $clog2(DEPTH);
  localparam logic [47:0] GRP_MAC = 48'h01_00_5e_00_00_07;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [PORTS-1:0] flush = '0;
  logic [11:0] vid = '0;
  logic allv = 1'b0;
  logic busy, done, rd_en, wr_en;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [ENTRY_W-1:0] rd_data, wr_data;

  logic ld_en = 1'b0;
  logic [ADDR_W-1:0] ld_addr = '0;
  logic [ENTRY_W-1:0] ld_data = '0;

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [ENTRY_W-1:0] shadow [DEPTH];
  logic [ENTRY_W-1:0] orig [DEPTH];
  logic [ADDR_W-1:0] q_addr [$];
  logic [ENTRY_W-1:0] q_data [$];
  logic [ADDR_W-1:0] rd_exp = '0;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mcast_flush_scan #(.PORTS(PORTS), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .start_i(start), .flush_mask_i(flush), .vid_i(vid),
    .all_vlan_i(allv), .busy_o(busy), .done_o(done),
    .tbl_rd_en_o(rd_en), .tbl_rd_addr_o(rd_addr), .tbl_rd_data_i(rd_data),
    .tbl_wr_en_o(wr_en), .tbl_wr_addr_o(wr_addr), .tbl_wr_data_o(wr_data)
  );

  // Table model, one-cycle read latency
  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    if (rd_en) rd_data <= mem[rd_addr];
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [ENTRY_W-1:0] act, input logic [ENTRY_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [ENTRY_W-1:0] mk(input logic [1:0] t, input logic [11:0] v,
                                            input logic [47:0] mac, input logic [PORTS-1:0] pm);
    logic [ENTRY_W-1:0] e;
    e = '0;
    e[61:60] = t;
    e[59:48] = v;
    e[47:0]  = mac;
    e[66 +: PORTS] = pm;
    return e;
  endfunction

  // Driver side of the scoreboard: expected writes from the requirements
  task automatic expect_scan(input logic [PORTS-1:0] m, input logic [11:0] v, input logic a);
    for (int i = 0; i < DEPTH; i++) begin
      logic [ENTRY_W-1:0] e;
      logic [PORTS-1:0] rem;
      e = shadow[i];
      if ((e[61:60] == 2'd1 || e[61:60] == 2'd3) && (a || e[59:48] == v) &&
          e[40] && !(&e[47:0]) && ((e[66 +: PORTS] & m) != '0)) begin
        rem = e[66 +: PORTS] & ~m;
        e[66 +: PORTS] = rem;
        if (rem == '0) e[61:60] = 2'd0;
        shadow[i] = e;
        q_addr.push_back(ADDR_W'(i));
        q_data.push_back(e);
      end
    end
  endtask

  // Monitor side of the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (rd_en) begin
        chk(rd_addr == rd_exp, "R2", "read index", ENTRY_W'(rd_addr), ENTRY_W'(rd_exp));
        rd_exp <= rd_exp + 1'b1;
      end
      if (wr_en) begin
        if (q_addr.size() == 0) begin
          chk(1'b0, "R11", "unexpected write", ENTRY_W'(wr_addr), '0);
        end else begin
          logic [ADDR_W-1:0] ea;
          logic [ENTRY_W-1:0] ed;
          ea = q_addr.pop_front();
          ed = q_data.pop_front();
          chk(wr_addr == ea, "R9", "write index", ENTRY_W'(wr_addr), ENTRY_W'(ea));
          chk(wr_data == ed, (ed[61:60] == 2'd0) ? "R10" : "R9", "write data", wr_data, ed);
        end
      end
    end
  end

  task automatic run_scan(input logic [PORTS-1:0] m, input logic [11:0] v, input logic a,
                          input bit chained, input int glitch_at);
    int n;
    bit seen;
    if (!chained) @(negedge clk);
    expect_scan(m, v, a);
    flush = m; vid = v; allv = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    chk(busy == 1'b1, "R2", "busy after start", ENTRY_W'(busy), 1);
    seen = 1'b0;
    while (!seen && n < 2 * DEPTH + 8) begin
      if (done) seen = 1'b1;
      else begin
        if (n == glitch_at) begin start = 1'b1; flush = '1; allv = 1'b1; end
        else if (n == glitch_at + 1) begin start = 1'b0; flush = m; allv = a; end
        @(negedge clk);
        n++;
      end
    end
    chk(seen && n == 2 * DEPTH + 1, "R4", "done cycle", ENTRY_W'(n), ENTRY_W'(2 * DEPTH + 1));
    chk(busy == 1'b0, "R4", "busy during done", ENTRY_W'(busy), 0);
  endtask

  task automatic settle_and_check_queue();
    @(negedge clk);
    chk(!done, "R4", "done lasts one cycle", ENTRY_W'(done), 0);
    chk(q_addr.size() == 0, "R11", "missing writes", ENTRY_W'(q_addr.size()), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R4 watchdog: actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) orig[i] = '0;
    orig[0] = mk(2'd1, 12'd0, GRP_MAC, 4'b0011);
    orig[1] = mk(2'd3, 12'd5, GRP_MAC, 4'b0001);
    orig[2] = mk(2'd3, 12'd7, GRP_MAC, 4'b0110);
    orig[3] = mk(2'd2, 12'd0, GRP_MAC, 4'b1111);
    orig[4] = mk(2'd1, 12'd0, 48'h00_11_22_33_44_55, 4'b1111);
    orig[5] = mk(2'd1, 12'd0, 48'hff_ff_ff_ff_ff_ff, 4'b1111);
    orig[6] = mk(2'd1, 12'd0, GRP_MAC, 4'b1000);
    orig[7] = mk(2'd0, 12'd0, GRP_MAC, 4'b1111);
    for (int i = 0; i < DEPTH; i++) begin
      shadow[i] = orig[i];
      @(negedge clk);
      ld_en = 1'b1; ld_addr = ADDR_W'(i); ld_data = orig[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
    chk(!busy && !done && !rd_en && !wr_en, "R1", "outputs in reset",
        ENTRY_W'({busy, done, rd_en, wr_en}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !rd_en && !wr_en, "R1", "outputs after reset",
        ENTRY_W'({busy, done, rd_en, wr_en}), 0);

    // Sweep A: port 0 across all VLANs
    run_scan(4'b0001, 12'd0, 1'b1, 1'b0, -5);
    settle_and_check_queue();
    chk(mem[3] == orig[3], "R5", "VLAN-type entry untouched", mem[3], orig[3]);
    chk(mem[7] == orig[7], "R5", "free entry untouched", mem[7], orig[7]);
    chk(mem[4] == orig[4], "R7", "unicast untouched", mem[4], orig[4]);
    chk(mem[5] == orig[5], "R7", "broadcast untouched", mem[5], orig[5]);
    chk(mem[6] == orig[6], "R8", "disjoint mask untouched", mem[6], orig[6]);
    chk(mem[1][61:60] == 2'd0, "R10", "emptied entry freed", ENTRY_W'(mem[1][61:60]), 0);

    // Sweep B: VLAN 7 only, with a start request in mid-sweep
    run_scan(4'b0110, 12'd7, 1'b0, 1'b0, 7);
    settle_and_check_queue();
    chk(mem[0] == shadow[0], "R6", "other VLAN untouched", mem[0], shadow[0]);
    chk(mem[6] == orig[6], "R3", "mid-sweep start ignored", mem[6], orig[6]);
    chk(mem[2][61:60] == 2'd0, "R10", "VLAN 7 entry freed", ENTRY_W'(mem[2][61:60]), 0);

    // Sweep C: empty flush set, then sweep D started in C's done cycle
    run_scan(4'b0000, 12'd0, 1'b1, 1'b0, -5);
    run_scan(4'b1010, 12'd0, 1'b1, 1'b1, -5);
    settle_and_check_queue();
    chk(mem[5] == orig[5], "R7", "broadcast kept after chained sweep", mem[5], orig[5]);
    for (int i = 0; i < DEPTH; i++)
      chk(mem[i] == shadow[i], "R11", "final table", mem[i], shadow[i]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule